// File: doc/BRIEF.md
# Two-Wire Write-Only Control Register Slave

This block is a receive-only serial slave for a two-wire bus (clock line and open-drain data line). It lets a bus master load a small bank of 8-bit control registers that other logic uses as static configuration. The master always sends a fixed header: the slave address byte, then a command byte, then a byte-count byte. The slave acknowledges the command and count bytes but does not use their contents. The data bytes that follow fill the registers strictly in order, starting at register 0. No byte selects a register, so to change a later register the master must also rewrite every earlier one.

Both bus lines are sampled by a fast system clock. Each line passes through a two-flop synchroniser and a glitch filter before start, stop and bit edges are decoded. The slave acknowledges a byte by asserting an output enable that pulls the data line low for the acknowledge bit. The whole register bank is presented as one flat parallel output. Register 0 bit 3 is the spread-spectrum enable and register 5 bits 7:5 select the spread mode and amount. The block only stores these fields.

Top module: `ctl_bus_slave`

## Requirements
- R1: A falling data line while the clock line is high is a start, and it begins address reception from any state. A rising data line while the clock line is high is a stop, and it returns the slave to idle. After a repeated start, the next byte is treated as an address byte.
- R2: Bytes are received MSB first on clock rising edges. For each byte that is accepted, `sda_oe_o` (1 = pull data low) rises after the clock falls at the end of bit 8 and falls at the next clock fall, so that the acknowledge bit reads low.
- R3: Only the address byte D2h (seven-bit address 69h with the write bit 0) is acknowledged. Any other address byte, including D3h, gets no acknowledge. After such a byte, every further byte is ignored until the next start and all registers keep their values.
- R4: The first two bytes after the address are acknowledged whatever their values, and they change no register.
- R5: Each data byte after the header is written to the next register, starting at register 0, and the write takes effect as the byte is acknowledged. A stop partway through keeps the registers already written and leaves the rest unchanged.
- R6: After reset, register 0 = 07h, register 1 = FFh, register 2 = FEh and registers 3 to 9 = 00h. Register k appears on `regs_o[8k+7:8k]`.
- R7: Only the first NUM_REGS (10) data bytes are written. Any later data byte gets no acknowledge and is discarded.
- R8: A pulse on either line that lasts fewer than FILT_LEN (3) system clocks is ignored. It creates no start, stop or extra bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 10x the bus bit rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe_o | output | 1 | 1 = drive the data line low (acknowledge) |
| regs_o | output | NUM_REGS*8 | Register bank, register k in bits [8k+7:8k] |

## Verification
A wrong byte counter shows up at the ports almost at once. Data lands one register off, or the header byte acknowledgements or the acknowledgement of the last data byte shift, and the register-by-register compare after the stop catches this. A wrong phase or bit counter moves or drops the acknowledge pulse within the same byte, and the acknowledge sample taken in the ninth bit exposes it. A wrong filter or edge decoder turns an injected glitch into a false stop or an extra bit, and the next acknowledge or the final register contents then differ from the model.

// File: rtl/sbus_ctl_pkg.sv
package sbus_ctl_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_RECV = 2'd1,
        PH_ACK  = 2'd2,
        PH_SKIP = 2'd3
    } phase_e;

    localparam int HDR_BYTES = 3;

    function automatic logic [7:0] reg_default(input int idx);
        case (idx)
            0:       return 8'h07;
            1:       return 8'hFF;
            2:       return 8'hFE;
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/sbus_line_filter.sv
module sbus_line_filter #(
    parameter int FILT_LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_o
);
    localparam int CNT_W = (FILT_LEN < 2) ? 1 : $clog2(FILT_LEN + 1);

    typedef struct packed {
        logic [1:0]       sync;
        logic [CNT_W-1:0] cnt;
        logic             level;
    } flt_t;

    flt_t q, d;

    always_comb begin
        d      = q;
        d.sync = {q.sync[0], line_i};
        if (q.sync[1] == q.level) begin
            d.cnt = '0;
        end else if (q.cnt == CNT_W'(FILT_LEN - 1)) begin
            d.level = q.sync[1];
            d.cnt   = '0;
        end else begin
            d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{sync: 2'b11, cnt: '0, level: 1'b1};
        end else begin
            q <= d;
        end
    end

    assign line_o = q.level;

endmodule

// File: rtl/sbus_byte_engine.sv
module sbus_byte_engine
    import sbus_ctl_pkg::*;
#(
    parameter int         NUM_REGS  = 10,
    parameter logic [7:0] ADDR_BYTE = 8'hD2,
    parameter int         IDX_W     = 4,
    parameter int         REG_IDX_W = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 scl_f,
    input  logic                 sda_f,
    output logic                 sda_oe_o,
    output logic                 wr_en_o,
    output logic [REG_IDX_W-1:0] wr_idx_o,
    output logic [7:0]           wr_data_o
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_REGS + HDR_BYTES);

    typedef struct packed {
        phase_e           phase;
        logic             scl_prev;
        logic             sda_prev;
        logic [3:0]       bit_cnt;
        logic [7:0]       shreg;
        logic [IDX_W-1:0] byte_idx;
        logic             oe;
    } eng_t;

    eng_t q, d;
    logic scl_rise, scl_fall, start_c, stop_c, accept;

    always_comb begin
        scl_rise = scl_f & ~q.scl_prev;
        scl_fall = ~scl_f & q.scl_prev;
        start_c  = scl_f & q.scl_prev & q.sda_prev & ~sda_f;
        stop_c   = scl_f & q.scl_prev & ~q.sda_prev & sda_f;

        if (q.byte_idx == '0) begin
            accept = (q.shreg == ADDR_BYTE);
        end else begin
            accept = (q.byte_idx < LAST_IDX);
        end

        d          = q;
        d.scl_prev = scl_f;
        d.sda_prev = sda_f;
        wr_en_o    = 1'b0;
        wr_idx_o   = REG_IDX_W'(q.byte_idx - IDX_W'(HDR_BYTES));
        wr_data_o  = q.shreg;

        if (start_c) begin
            d.phase    = PH_RECV;
            d.bit_cnt  = '0;
            d.byte_idx = '0;
            d.oe       = 1'b0;
        end else if (stop_c) begin
            d.phase = PH_IDLE;
            d.oe    = 1'b0;
        end else begin
            case (q.phase)
                PH_RECV: begin
                    if (scl_rise && q.bit_cnt < 4'd8) begin
                        d.shreg   = {q.shreg[6:0], sda_f};
                        d.bit_cnt = q.bit_cnt + 4'd1;
                    end else if (scl_fall && q.bit_cnt == 4'd8) begin
                        if (accept) begin
                            d.phase = PH_ACK;
                            d.oe    = 1'b1;
                            wr_en_o = (q.byte_idx >= IDX_W'(HDR_BYTES));
                        end else begin
                            d.phase = PH_SKIP;
                        end
                    end
                end
                PH_ACK: begin
                    if (scl_fall) begin
                        d.oe      = 1'b0;
                        d.phase   = PH_RECV;
                        d.bit_cnt = '0;
                        if (q.byte_idx != LAST_IDX) begin
                            d.byte_idx = q.byte_idx + 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{phase: PH_IDLE, scl_prev: 1'b1, sda_prev: 1'b1,
                   bit_cnt: '0, shreg: '0, byte_idx: '0, oe: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign sda_oe_o = q.oe;

endmodule

// File: rtl/sbus_reg_bank.sv
module sbus_reg_bank
    import sbus_ctl_pkg::*;
#(
    parameter int NUM_REGS  = 10,
    parameter int REG_IDX_W = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en_i,
    input  logic [REG_IDX_W-1:0]    wr_idx_i,
    input  logic [7:0]              wr_data_i,
    output logic [NUM_REGS*8-1:0]   regs_o
);
    localparam logic [REG_IDX_W:0] NUM_REGS_C = (REG_IDX_W + 1)'(NUM_REGS);

    logic [7:0] regs_d [NUM_REGS];
    logic [7:0] regs_q [NUM_REGS];

    always_comb begin
        regs_d = regs_q;
        if (wr_en_i && ({1'b0, wr_idx_i} < NUM_REGS_C)) begin
            regs_d[wr_idx_i] = wr_data_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < NUM_REGS; k++) begin
                regs_q[k] <= reg_default(k);
            end
        end else begin
            regs_q <= regs_d;
        end
    end

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_flat
        assign regs_o[g*8 +: 8] = regs_q[g];
    end

endmodule

// File: rtl/ctl_bus_slave.sv
module ctl_bus_slave
    import sbus_ctl_pkg::*;
#(
    parameter int         NUM_REGS  = 10,
    parameter logic [7:0] ADDR_BYTE = 8'hD2,
    parameter int         FILT_LEN  = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scl_i,
    input  logic                  sda_i,
    output logic                  sda_oe_o,
    output logic [NUM_REGS*8-1:0] regs_o
);
    localparam int IDX_W     = $clog2(NUM_REGS + HDR_BYTES + 1);
    localparam int REG_IDX_W = (NUM_REGS < 2) ? 1 : $clog2(NUM_REGS);

    logic [1:0]           raw_lines;
    logic [1:0]           filt_lines;
    logic                 scl_filt;
    logic                 sda_filt;
    logic                 wr_en;
    logic [REG_IDX_W-1:0] wr_idx;
    logic [7:0]           wr_data;

    assign raw_lines = {sda_i, scl_i};

    for (genvar g = 0; g < 2; g++) begin : g_line
        sbus_line_filter #(.FILT_LEN(FILT_LEN)) u_flt (
            .clk    (clk),
            .rst_n  (rst_n),
            .line_i (raw_lines[g]),
            .line_o (filt_lines[g])
        );
    end

    assign scl_filt = filt_lines[0];
    assign sda_filt = filt_lines[1];

    sbus_byte_engine #(
        .NUM_REGS  (NUM_REGS),
        .ADDR_BYTE (ADDR_BYTE),
        .IDX_W     (IDX_W),
        .REG_IDX_W (REG_IDX_W)
    ) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_f     (scl_filt),
        .sda_f     (sda_filt),
        .sda_oe_o  (sda_oe_o),
        .wr_en_o   (wr_en),
        .wr_idx_o  (wr_idx),
        .wr_data_o (wr_data)
    );

    sbus_reg_bank #(
        .NUM_REGS  (NUM_REGS),
        .REG_IDX_W (REG_IDX_W)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en),
        .wr_idx_i  (wr_idx),
        .wr_data_i (wr_data),
        .regs_o    (regs_o)
    );

endmodule

// File: rtl/sbus_ctl_checker.sv
module sbus_ctl_checker #(
    parameter int NUM_REGS  = 10,
    parameter int REG_IDX_W = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  scl_f,
    input logic                  sda_oe,
    input logic                  wr_en,
    input logic [REG_IDX_W-1:0]  wr_idx,
    input logic [NUM_REGS*8-1:0] regs
);
    localparam logic [REG_IDX_W:0] NUM_REGS_C = (REG_IDX_W + 1)'(NUM_REGS);

    // R2: acknowledge drive starts only while the clock line is low
    a_r2_ack_starts_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_f);

    // R2: acknowledge drive ends only while the clock line is low
    a_r2_ack_ends_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sda_oe) |-> !scl_f);

    // R5: a register write is always accompanied by an acknowledge
    a_r5_write_is_acked: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> sda_oe);

    // R7: no write index past the last register
    a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> ({1'b0, wr_idx} < NUM_REGS_C));

    // R3/R4: the bank changes only on a write strobe
    a_r4_regs_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(regs));

endmodule

bind ctl_bus_slave sbus_ctl_checker #(
    .NUM_REGS  (NUM_REGS),
    .REG_IDX_W (REG_IDX_W)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .scl_f  (scl_filt),
    .sda_oe (sda_oe_o),
    .wr_en  (wr_en),
    .wr_idx (wr_idx),
    .regs   (regs_o)
);

// File: tb/tb_ctl_bus_slave.sv
module tb_ctl_bus_slave;
    localparam int NREG = 10;
    localparam int Q    = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_drv = 1'b1;
    logic sda_drv = 1'b1;
    logic sda_oe;
    logic [NREG*8-1:0] regs;
    wire  sda_line = sda_drv & ~sda_oe;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;
    logic [7:0] exp_r [NREG];

    always #4 clk = ~clk;

    ctl_bus_slave dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_drv),
        .sda_i    (sda_line),
        .sda_oe_o (sda_oe),
        .regs_o   (regs)
    );

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic check_regs(input string tag);
        for (int k = 0; k < NREG; k++) chk(tag, 32'(regs[k*8 +: 8]), 32'(exp_r[k]));
    endtask

    task automatic bus_start();
        sda_drv = 1'b1; wt(Q);
        scl_drv = 1'b1; wt(Q);
        sda_drv = 1'b0; wt(Q);
        scl_drv = 1'b0; wt(Q);
    endtask

    task automatic bus_stop();
        sda_drv = 1'b0; wt(Q);
        scl_drv = 1'b1; wt(Q);
        sda_drv = 1'b1; wt(4 * Q);
    endtask

    task automatic send_byte(input logic [7:0] b, input bit glitch, output bit acked);
        for (int i = 7; i >= 0; i--) begin
            sda_drv = b[i]; wt(Q);
            scl_drv = 1'b1; wt(Q);
            if (glitch && i == 7) begin
                sda_drv = 1'b1; wt(1); sda_drv = b[i];
            end
            if (glitch && i == 4) begin
                scl_drv = 1'b0; wt(1); scl_drv = 1'b1;
            end
            wt(Q);
            scl_drv = 1'b0; wt(Q);
        end
        sda_drv = 1'b1; wt(Q);
        scl_drv = 1'b1; wt(Q);
        acked = (sda_line == 1'b0);
        wt(Q);
        scl_drv = 1'b0; wt(Q);
    endtask

    task automatic put(input logic [7:0] b, input bit exp_ack, input string tag, input bit glitch = 1'b0);
        bit a;
        send_byte(b, glitch, a);
        chk({tag, " ack"}, 32'(a), 32'(exp_ack));
        chk("R2 release after ack bit", 32'(sda_oe), 32'd0);
    endtask

    task automatic hdr(input logic [7:0] cmd, input logic [7:0] cnt);
        bus_start();
        put(8'hD2, 1'b1, "R3 address D2");
        put(cmd, 1'b1, "R4 command");
        put(cnt, 1'b1, "R4 count");
    endtask

    task automatic t_reset();
        for (int k = 0; k < NREG; k++) exp_r[k] = 8'h00;
        exp_r[0] = 8'h07; exp_r[1] = 8'hFF; exp_r[2] = 8'hFE;
        check_regs("R6 reset default");
        chk("R2 idle no drive", 32'(sda_oe), 32'd0);
    endtask

    task automatic t_basic();
        hdr(8'h00, 8'h03);
        put(8'h0F, 1'b1, "R5 data0");
        put(8'hA5, 1'b1, "R5 data1");
        put(8'h5A, 1'b1, "R5 data2");
        bus_stop();
        exp_r[0] = 8'h0F; exp_r[1] = 8'hA5; exp_r[2] = 8'h5A;
        check_regs("R5 sequential write");
    endtask

    task automatic t_header_ignored();
        hdr(8'hFF, 8'h01);
        check_regs("R4 header changes nothing");
        put(8'h08, 1'b1, "R4 data after header");
        bus_stop();
        exp_r[0] = 8'h08;
        check_regs("R4 data starts at reg0");
    endtask

    task automatic t_bad_addr();
        bus_start();
        put(8'hD0, 1'b0, "R3 wrong address");
        put(8'h00, 1'b0, "R3 ignored byte");
        put(8'h11, 1'b0, "R3 ignored byte");
        put(8'h22, 1'b0, "R3 ignored byte");
        bus_stop();
        bus_start();
        put(8'hD3, 1'b0, "R3 read address");
        put(8'h44, 1'b0, "R3 ignored byte");
        bus_stop();
        check_regs("R3 regs unchanged");
    endtask

    task automatic t_abort();
        hdr(8'h00, 8'h00);
        put(8'h11, 1'b1, "R5 abort data0");
        put(8'h22, 1'b1, "R5 abort data1");
        bus_stop();
        exp_r[0] = 8'h11; exp_r[1] = 8'h22;
        check_regs("R5 partial write kept");
    endtask

    task automatic t_overflow();
        hdr(8'h00, 8'h0A);
        for (int k = 0; k < NREG; k++) begin
            put(8'(k * 17 + 3), 1'b1, "R7 data in range");
            exp_r[k] = 8'(k * 17 + 3);
        end
        put(8'hEE, 1'b0, "R7 extra byte");
        bus_stop();
        check_regs("R7 extra discarded");
    endtask

    task automatic t_restart();
        bus_start();
        put(8'hD2, 1'b1, "R1 address");
        put(8'h00, 1'b1, "R1 command");
        bus_start();
        put(8'h55, 1'b0, "R1 byte after restart is address");
        bus_start();
        put(8'hD2, 1'b1, "R1 address after restart");
        put(8'h00, 1'b1, "R1 command");
        put(8'h00, 1'b1, "R1 count");
        put(8'h77, 1'b1, "R1 data");
        bus_stop();
        exp_r[0] = 8'h77;
        check_regs("R1 restart write");
    endtask

    task automatic t_glitch();
        hdr(8'h00, 8'h02);
        put(8'h3C, 1'b1, "R8 glitched byte", 1'b1);
        put(8'h99, 1'b1, "R8 next byte");
        bus_stop();
        exp_r[0] = 8'h3C; exp_r[1] = 8'h99;
        check_regs("R8 glitch ignored");
    endtask

    initial begin
        wt(5);
        rst_n = 1'b1;
        wt(10);
        t_reset();
        t_basic();
        t_header_ignored();
        t_bad_addr();
        t_abort();
        t_overflow();
        t_restart();
        t_glitch();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
            $finish;
        end
    end

endmodule